// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Sequencer

This block is a small accumulator processor that executes one instruction at a time. Every instruction goes through a fixed series of states: fetch, decode, operand address and execute. All data moves through explicit internal registers:

- a program counter;
- an instruction register;
- a memory address register and a memory data register;
- a four-bit condition register;
- an accumulator;
- eight general registers. Two of them act as the base and the index for array addressing.

The block drives one synchronous, word-addressed memory port. A read returns its data one clock after the address appears on the port. A write completes in a single cycle in which the write enable is high. The block also has one level-sensitive interrupt request input.

An instruction is a 16-bit word with these fields:

- bits [15:12]: opcode;
- bits [11:9]: operand mode;
- bits [8:6]: register select;
- bits [5:0]: an unsigned address or constant field.

Operands reach the accumulator by one of five modes. The interrupt entry saves the program counter and the condition register into shadow registers. It then jumps through a vector word held in low memory. A return instruction brings both saved values back. An undefined encoding stops the processor until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: After reset the program counter holds 2. Each fetch places the program counter in the address register, reads the word into the data register and then into the instruction register, and adds one to the program counter. Instructions therefore run in address order unless a jump or an interrupt intervenes.
- R2: Mode 0 (immediate) uses the 6-bit field, zero-extended to 16 bits, as the operand. It performs no operand memory access.
- R3: Mode 1 (direct) places the field in the address register. The word read from that address becomes the operand.
- R4: Mode 2 (indirect) places the field in the address register, reads the word there and loads it back into the address register. A second read at that pointer address supplies the operand. A store in this mode writes to the pointer address and leaves the pointer word unchanged.
- R5: Mode 3 (indexed) forms the address as general register 6 plus general register 7. The field is ignored.
- R6: Mode 4 (register direct) takes the operand from the general register selected by bits [8:6]. A store in this mode writes the accumulator into that register. Neither case accesses memory.
- R7: Opcode 0 loads the operand into the accumulator and leaves the flags unchanged. Opcodes 2 to 6 (add, subtract, AND, OR, XOR) write accumulator-op-operand to the accumulator and set the flags. The flag register bits are: bit 0 zero, bit 1 carry, bit 2 signed overflow, bit 3 sign. On subtract, carry is the carry out of acc + ~operand + 1. The logic operations clear carry and overflow.
- R8: Opcode 1 (store) copies the accumulator into the data register. It then writes the data register to memory at the address register in one cycle with the write enable high. It works in direct, indirect and indexed modes.
- R9: An interrupt request is taken only at an instruction boundary. Entry saves the program counter and the flags and loads the program counter from memory word 1. Opcode 8 (return) restores both saved values, so the interrupted program resumes with its original flags.
- R10: While the service routine runs, further requests are masked. A request held high for the whole routine causes exactly one entry.
- R11: Any of the following halts the block: an opcode from 9 to 15, a mode from 5 to 7 with an opcode from 0 to 6, or a store in immediate mode. Once halted, halted_o stays high, no memory write occurs and nothing changes until reset.
- R12: Opcode 7 (jump) loads the zero-extended 6-bit field into the program counter and ignores the mode bits.
- R13: During reset the accumulator and flags read zero, halted_o is low and the write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | AW | Memory word address, driven from the address register |
| mem_wdata_o | output | DW | Memory write data, driven from the data register |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | DW | Memory read data, valid one clock after the address |
| irq_i | input | 1 | Interrupt request, level sensitive |
| acc_o | output | DW | Accumulator contents |
| sr_o | output | 4 | Condition flags {sign, overflow, carry, zero} |
| halted_o | output | 1 | High once an undefined encoding has been decoded |

## Verification
The bench sweeps all five arithmetic and logic operations over an 8-by-8 grid of edge operands, including 0, 1, 0x7FFF, 0x8000 and 0xFFFF. A wrong carry polarity on subtract, or a missed signed overflow at the sign boundary, shows up there as a bad flag nibble. Indirect mode is checked for both a load and a store. A design that skips the second read returns the pointer instead of the data, and one that stores to the pointer cell overwrites the pointer word. The interrupt test holds the request high through the whole routine and checks for exactly one entry. It also checks that the original flags come back and that the main loop resumes with the routine's accumulator value. A missing mask would re-enter the routine, and an unrestored flag register would leave the routine's flags behind. Halting is checked with an instruction that follows the undefined one, which must never write memory.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int IW = 16;
  localparam int NREG = 8;
  localparam int SELW = $clog2(NREG);
  localparam int FLDW = 6;
  localparam int BASE_REG = 6;
  localparam int INDEX_REG = 7;

  typedef enum logic [3:0] {
    OP_LDA = 4'd0, OP_STA = 4'd1, OP_ADD = 4'd2, OP_SUB = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_JMP = 4'd7,
    OP_RET = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    MD_IMM = 3'd0, MD_DIR = 3'd1, MD_IND = 3'd2, MD_IDX = 3'd3, MD_REG = 3'd4
  } mode_e;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_DEC, S_ADR, S_PT1, S_PT2, S_RD1, S_RD2,
    S_EX, S_WR, S_INT0, S_INT1, S_INT2, S_HALT
  } state_e;

  typedef struct packed {
    logic s;
    logic v;
    logic c;
    logic z;
  } flags_t;
endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [IW-1:0]   ir_i,
  output logic [3:0]      op_o,
  output logic [2:0]      mode_o,
  output logic [SELW-1:0] sel_o,
  output logic [FLDW-1:0] fld_o,
  output logic            illegal_o
);
  logic uses_mode;

  assign op_o   = ir_i[15:12];
  assign mode_o = ir_i[11:9];
  assign sel_o  = ir_i[8:6];
  assign fld_o  = ir_i[5:0];

  assign uses_mode = (op_o <= OP_XOR);

  always_comb begin
    illegal_o = 1'b0;
    if (op_o > OP_RET) illegal_o = 1'b1;
    if (uses_mode && (mode_o > MD_REG)) illegal_o = 1'b1;
    if ((op_o == OP_STA) && (mode_o == MD_IMM)) illegal_o = 1'b1;
  end
endmodule

// File: rtl/acc_cpu_regfile.sv
module acc_cpu_regfile
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [SELW-1:0] wsel_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [SELW-1:0] rsel_i,
  output logic [DW-1:0]   rdata_o,
  output logic [DW-1:0]   base_o,
  output logic [DW-1:0]   index_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= '0;
      else if (we_i && (wsel_i == SELW'(g)))       regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[rsel_i];
  assign base_o  = regs_q[BASE_REG];
  assign index_o = regs_q[INDEX_REG];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output flags_t        fl_o
);
  logic [DW:0] sum;

  always_comb begin
    sum   = '0;
    res_o = b_i;
    fl_o  = '0;
    unique case (op_i)
      OP_ADD: begin
        sum    = {1'b0, a_i} + {1'b0, b_i};
        res_o  = sum[DW-1:0];
        fl_o.c = sum[DW];
        fl_o.v = (a_i[DW-1] == b_i[DW-1]) && (res_o[DW-1] != a_i[DW-1]);
      end
      OP_SUB: begin
        sum    = {1'b0, a_i} + {1'b0, ~b_i} + {{DW{1'b0}}, 1'b1};
        res_o  = sum[DW-1:0];
        fl_o.c = sum[DW];
        fl_o.v = (a_i[DW-1] != b_i[DW-1]) && (res_o[DW-1] != a_i[DW-1]);
      end
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      default: res_o = b_i;
    endcase
    fl_o.z = (res_o == '0);
    fl_o.s = res_o[DW-1];
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int RESET_PC = 2,
  parameter int VEC_ADDR = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          irq_i,
  output logic [DW-1:0] acc_o,
  output logic [3:0]    sr_o,
  output logic          halted_o
);
  state_e        state_q;
  logic [AW-1:0] pc_q, mar_q, pc_sh_q;
  logic [DW-1:0] mdr_q, acc_q;
  logic [IW-1:0] ir_q;
  flags_t        sr_q, sr_sh_q;
  logic          in_isr_q;

  logic [3:0]      op;
  logic [2:0]      mode;
  logic [SELW-1:0] sel;
  logic [FLDW-1:0] fld;
  logic            illegal;
  logic [AW-1:0]   fld_a;

  logic [DW-1:0] rf_rdata, rf_base, rf_index, idx_sum, opnd, alu_res;
  logic          rf_we, alu_upd;
  flags_t        alu_fl;

  acc_cpu_decode u_dec (
    .ir_i(ir_q), .op_o(op), .mode_o(mode), .sel_o(sel), .fld_o(fld),
    .illegal_o(illegal)
  );

  acc_cpu_regfile #(.DW(DW)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(rf_we), .wsel_i(sel),
    .wdata_i(acc_q), .rsel_i(sel), .rdata_o(rf_rdata),
    .base_o(rf_base), .index_o(rf_index)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .op_i(op), .a_i(acc_q), .b_i(opnd), .res_o(alu_res), .fl_o(alu_fl)
  );

  assign fld_a   = AW'(fld);
  assign idx_sum = rf_base + rf_index;
  assign alu_upd = (op >= OP_ADD) && (op <= OP_XOR);
  assign rf_we   = (state_q == S_ADR) && !illegal && (op == OP_STA) &&
                   (mode == MD_REG);

  // operand: memory word in execute, else immediate or register direct
  always_comb begin
    if (state_q == S_EX)       opnd = mdr_q;
    else if (mode == MD_IMM)   opnd = DW'(fld);
    else                       opnd = rf_rdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_F0;
      pc_q     <= AW'(RESET_PC);
      mar_q    <= '0;
      mdr_q    <= '0;
      ir_q     <= '0;
      acc_q    <= '0;
      sr_q     <= '0;
      pc_sh_q  <= '0;
      sr_sh_q  <= '0;
      in_isr_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_F0: begin
          if (irq_i && !in_isr_q) state_q <= S_INT0;
          else begin
            mar_q   <= pc_q;
            state_q <= S_F1;
          end
        end
        S_F1: state_q <= S_F2;
        S_F2: begin
          mdr_q   <= mem_rdata_i;
          pc_q    <= pc_q + 1'b1;
          state_q <= S_DEC;
        end
        S_DEC: begin
          ir_q    <= mdr_q;
          state_q <= S_ADR;
        end
        S_ADR: begin
          if (illegal) state_q <= S_HALT;
          else if (op == OP_JMP) begin
            pc_q    <= fld_a;
            state_q <= S_F0;
          end else if (op == OP_RET) begin
            pc_q     <= pc_sh_q;
            sr_q     <= sr_sh_q;
            in_isr_q <= 1'b0;
            state_q  <= S_F0;
          end else begin
            unique case (mode)
              MD_IMM, MD_REG: begin
                if (op != OP_STA) begin
                  acc_q <= alu_res;
                  if (alu_upd) sr_q <= alu_fl;
                end
                state_q <= S_F0;
              end
              MD_DIR: begin
                mar_q   <= fld_a;
                state_q <= S_RD1;
              end
              MD_IND: begin
                mar_q   <= fld_a;
                state_q <= S_PT1;
              end
              default: begin
                mar_q   <= idx_sum[AW-1:0];
                state_q <= S_RD1;
              end
            endcase
          end
        end
        S_PT1: state_q <= S_PT2;
        S_PT2: begin
          mar_q   <= mem_rdata_i[AW-1:0];
          state_q <= S_RD1;
        end
        S_RD1: begin
          if (op == OP_STA) begin
            mdr_q   <= acc_q;
            state_q <= S_WR;
          end else state_q <= S_RD2;
        end
        S_RD2: begin
          mdr_q   <= mem_rdata_i;
          state_q <= S_EX;
        end
        S_EX: begin
          acc_q <= alu_res;
          if (alu_upd) sr_q <= alu_fl;
          state_q <= S_F0;
        end
        S_WR: state_q <= S_F0;
        S_INT0: begin
          pc_sh_q  <= pc_q;
          sr_sh_q  <= sr_q;
          in_isr_q <= 1'b1;
          mar_q    <= AW'(VEC_ADDR);
          state_q  <= S_INT1;
        end
        S_INT1: state_q <= S_INT2;
        S_INT2: begin
          pc_q    <= mem_rdata_i[AW-1:0];
          state_q <= S_F0;
        end
        default: state_q <= S_HALT;
      endcase
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign mem_we_o    = (state_q == S_WR);
  assign acc_o       = acc_q;
  assign sr_o        = sr_q;
  assign halted_o    = (state_q == S_HALT);
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input state_e        state_q,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] pc_sh_q,
  input flags_t        sr_q,
  input flags_t        sr_sh_q,
  input logic          in_isr_q,
  input logic          halted_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [DW-1:0] acc_o
);
  // R1
  a_r1_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_F2) |=> (pc_q == $past(pc_q) + 1'b1));

  // R7
  a_r7_flags_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != S_EX) && (state_q != S_ADR)) |=> $stable(sr_q));

  // R8
  a_r8_store_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == acc_o));

  // R9
  a_r9_save_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_INT0) |=> ((pc_sh_q == $past(pc_q)) && (sr_sh_q == $past(sr_q))));

  // R10
  a_r10_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_isr_q && (state_q == S_F0)) |=> (state_q == S_F1));

  // R11
  a_r11_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  a_r11_halt_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o);
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_q(state_q), .pc_q(pc_q),
  .pc_sh_q(pc_sh_q), .sr_q(sr_q), .sr_sh_q(sr_sh_q), .in_isr_q(in_isr_q),
  .halted_o(halted_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
  .acc_o(acc_o)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          we, irq;
  logic [DW-1:0] acc;
  logic [3:0]    sr;
  logic          halted;

  logic [DW-1:0] mem [256];
  int            isr_hits;
  int            total = 0;
  int            bad = 0;

  always #4 clk = ~clk;

  acc_cpu #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_we_o(we), .mem_rdata_i(rdata), .irq_i(irq), .acc_o(acc),
    .sr_o(sr), .halted_o(halted)
  );

  always @(posedge clk) begin
    rdata <= mem[addr];
    if (we) begin
      mem[addr] <= wdata;
      if (addr == 8'd50) isr_hits <= isr_hits + 1;
    end
  end

  function automatic logic [15:0] ins(int op, int md, int sl, int f);
    logic [3:0] o = op[3:0];
    logic [2:0] m = md[2:0];
    logic [2:0] s = sl[2:0];
    logic [5:0] fl = f[5:0];
    return {o, m, s, fl};
  endfunction

  localparam logic [15:0] HALT = 16'hF000;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 256; k++) mem[k] = 16'h0000;
  endtask

  task automatic start();
    rst_n = 1'b0;
    irq = 1'b0;
    isr_hits = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(string req);
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({req, " reached halt"}, {15'h0, halted}, 16'h0001);
  endtask

  // flag model: {s, v, c, z}
  function automatic logic [19:0] model(int op, logic [15:0] a, logic [15:0] b);
    logic [16:0] s17;
    logic [15:0] r;
    logic c, v;
    c = 1'b0; v = 1'b0; r = 16'h0;
    case (op)
      2: begin s17 = {1'b0, a} + {1'b0, b}; r = s17[15:0]; c = s17[16];
               v = (a[15] == b[15]) && (r[15] != a[15]); end
      3: begin s17 = {1'b0, a} + {1'b0, ~b} + 17'd1; r = s17[15:0]; c = s17[16];
               v = (a[15] != b[15]) && (r[15] != a[15]); end
      4: r = a & b;
      5: r = a | b;
      default: r = a ^ b;
    endcase
    return {r[15], v, c, (r == 16'h0), r};
  endfunction

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] vals [8];
    logic [19:0] e;
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234,
             16'h5555, 16'hAAAA};
    irq = 1'b0;

    // R13: reset state
    clear_mem();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R13 acc", acc, 16'h0);
    check("R13 sr", {12'h0, sr}, 16'h0);
    check("R13 halted", {15'h0, halted}, 16'h0);
    check("R13 we", {15'h0, we}, 16'h0);

    // R1 / R2: ordered sequence with immediates, zero-extended max constant
    clear_mem();
    mem[2] = ins(0, 0, 0, 1);  mem[3] = ins(1, 1, 0, 20);
    mem[4] = ins(0, 0, 0, 2);  mem[5] = ins(1, 1, 0, 21);
    mem[6] = ins(0, 0, 0, 63); mem[7] = ins(1, 1, 0, 22);
    mem[8] = ins(2, 0, 0, 5);  mem[9] = HALT;
    start();
    run_to_halt("R1");
    check("R1 first", mem[20], 16'd1);
    check("R1 second", mem[21], 16'd2);
    check("R2 imm 63", mem[22], 16'd63);
    check("R2 add imm", acc, 16'd68);

    // R3 / R7 / R8: sweep of all ALU ops in direct mode
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int op = 2; op <= 6; op++) begin
          clear_mem();
          mem[2] = ins(0, 1, 0, 10);
          mem[3] = ins(op, 1, 0, 11);
          mem[4] = ins(1, 1, 0, 12);
          mem[5] = HALT;
          mem[10] = vals[i];
          mem[11] = vals[j];
          start();
          run_to_halt("R3");
          e = model(op, vals[i], vals[j]);
          check("R3 R8 result", mem[12], e[15:0]);
          check("R7 flags", {12'h0, sr}, {12'h0, e[19:16]});
        end
      end
    end

    // R7: load leaves flags untouched
    clear_mem();
    mem[2] = ins(0, 0, 0, 3); mem[3] = ins(3, 0, 0, 3);
    mem[4] = ins(0, 0, 0, 9); mem[5] = HALT;
    start();
    run_to_halt("R7");
    check("R7 load keeps flags", {12'h0, sr}, 16'h0003);
    check("R7 load acc", acc, 16'd9);

    // R4: indirect load and store
    clear_mem();
    mem[2] = ins(0, 2, 0, 30); mem[3] = ins(1, 1, 0, 20);
    mem[4] = ins(0, 0, 0, 17); mem[5] = ins(1, 2, 0, 30);
    mem[6] = HALT;
    mem[30] = 16'h0090; mem[8'h90] = 16'hBEEF;
    start();
    run_to_halt("R4");
    check("R4 indirect load", mem[20], 16'hBEEF);
    check("R4 indirect store", mem[8'h90], 16'd17);
    check("R4 pointer intact", mem[30], 16'h0090);

    // R5 / R6: indexed via R6+R7, registers written by register-direct store
    clear_mem();
    mem[2] = ins(0, 0, 0, 8);  mem[3] = ins(1, 4, 6, 0);
    mem[4] = ins(0, 0, 0, 56); mem[5] = ins(1, 4, 7, 0);
    mem[6] = ins(0, 3, 0, 5);  mem[7] = ins(1, 1, 0, 20);
    mem[8] = ins(0, 0, 0, 33); mem[9] = ins(1, 3, 0, 0);
    mem[10] = HALT;
    mem[64] = 16'h7777;
    start();
    run_to_halt("R5");
    check("R5 indexed load", mem[20], 16'h7777);
    check("R5 indexed store", mem[64], 16'd33);

    // R6: register direct operand
    clear_mem();
    mem[2] = ins(0, 0, 0, 17); mem[3] = ins(1, 4, 3, 0);
    mem[4] = ins(0, 0, 0, 40); mem[5] = ins(2, 4, 3, 0);
    mem[6] = ins(6, 4, 3, 0);  mem[7] = HALT;
    start();
    run_to_halt("R6");
    check("R6 reg direct", acc, 16'd40);
    check("R6 flags", {12'h0, sr}, 16'h0000);

    // R12: jump skips instructions
    clear_mem();
    mem[2] = ins(7, 6, 0, 9); mem[3] = ins(0, 0, 0, 1); mem[4] = ins(1, 1, 0, 20);
    mem[5] = HALT;
    mem[9] = ins(0, 0, 0, 9); mem[10] = ins(1, 1, 0, 21); mem[11] = HALT;
    start();
    run_to_halt("R12");
    check("R12 skipped", mem[20], 16'd0);
    check("R12 target", mem[21], 16'd9);

    // R11: undefined opcode, undefined mode, immediate store
    clear_mem();
    mem[2] = ins(0, 0, 0, 7); mem[3] = HALT; mem[4] = ins(1, 1, 0, 20);
    start();
    run_to_halt("R11");
    repeat (40) @(negedge clk);
    check("R11 still halted", {15'h0, halted}, 16'h0001);
    check("R11 no write", mem[20], 16'd0);
    check("R11 acc frozen", acc, 16'd7);

    clear_mem();
    mem[2] = ins(0, 5, 0, 7); mem[3] = ins(1, 1, 0, 20);
    start();
    run_to_halt("R11 mode");
    check("R11 bad mode acc", acc, 16'd0);

    clear_mem();
    mem[2] = ins(0, 0, 0, 4); mem[3] = ins(1, 0, 0, 20); mem[4] = ins(1, 1, 0, 21);
    start();
    run_to_halt("R11 imm store");
    repeat (20) @(negedge clk);
    check("R11 imm store no write", mem[20], 16'd0);
    check("R11 imm store next", mem[21], 16'd0);

    // R9 / R10: interrupt entry, masking, return
    clear_mem();
    mem[1] = 16'd40;
    mem[2] = ins(0, 0, 0, 3); mem[3] = ins(3, 0, 0, 3);
    mem[4] = ins(1, 1, 0, 52); mem[5] = ins(7, 0, 0, 4);
    mem[40] = ins(1, 1, 0, 50); mem[41] = ins(0, 0, 0, 5);
    mem[42] = ins(2, 0, 0, 1);  mem[43] = ins(1, 1, 0, 51);
    mem[44] = ins(8, 0, 0, 0);
    mem[50] = 16'hFFFF;
    start();
    repeat (60) @(negedge clk);
    check("R9 pre flags", {12'h0, sr}, 16'h0003);
    irq = 1'b1;
    begin
      int n = 0;
      while (mem[51] != 16'd6 && n < 1000) begin
        @(negedge clk);
        n++;
      end
    end
    irq = 1'b0;
    repeat (80) @(negedge clk);
    check("R9 isr stored", mem[50], 16'd0);
    check("R10 single entry", 16'(isr_hits), 16'd1);
    check("R9 flags restored", {12'h0, sr}, 16'h0003);
    check("R9 resumed", mem[52], 16'd6);
    check("R9 acc", acc, 16'd6);
    check("R9 not halted", {15'h0, halted}, 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule